// File: doc/BRIEF.md
# Serial FIFO Extension Interrupt Controller

This block is the control side of a serial port that has been extended with a pair of large external FIFOs, one for transmit and one for receive, placed next to a 16550-style UART. A host reaches it through a small window of byte registers. Through that window the host sets the operating mode, chooses which interrupt causes are enabled, reads a live snapshot of FIFO occupancy and pending causes, flushes either FIFO, and programs a one-shot hardware timer.

The FIFOs report their occupancy flags to the block. They also report every host pop from the receive side and every host push to the transmit side. The receive side additionally reports a character-timeout event. Each interrupt cause has its own pending bit, and each pending bit has its own clearing rule. Those rules are tied to data accesses, status reads, FIFO flushes or a timer disable. The enabled pending causes are merged onto a single interrupt line. That line either follows the merged condition (level style) or emits a one-cycle pulse each time the merged condition becomes true (edge style).

Two outputs gate data movement between the UART and the FIFOs, based on the UART's two general-purpose modem-control outputs. The timer counts in steps of 0.2 ms, derived from the clock frequency parameter. It raises its cause once and then stays quiet until it is disabled and enabled again.

Top module: `sfx_irq_ctrl`

## Requirements
- R1: After reset, the register window reads as follows: mode register (offset 0) reads 0x04, interrupt enable (offset 1) reads 0x00, timer interval (offset 3) reads 0x00, timer control (offset 4) reads 0x00. The `irq` output is 0. Read data is registered and appears on `reg_rdata` in the cycle after the cycle in which `reg_rd` is sampled.
- R2: The mode register fields are bit4 = level-style interrupt (1) or edge-style interrupt (0), bit3 = automatic RTS/CTS flow control, bit2 = external FIFO enable, and bit0 = swap of the two 8-byte halves of a 16-byte window. Bits 3, 2 and 0 drive `flow_auto_en`, `fifo_en` and `half_swap`. Bit1 is reserved: writes to it are ignored and it always reads 0. Bits 7:5 read 0.
- R3: A read of offset 2 returns the status byte, with bit7 = timer cause pending, bit6 = character-timeout cause pending, bit5 = NOT `rx_full` (0 means the receive FIFO is full), bit4 = `rx_half`, bit3 = `rx_empty`, bit2 = `tx_full`, bit1 = `tx_half`, bit0 = `tx_empty`. The returned value is the value before any clear caused by that same read.
- R4: The receive half-full cause becomes pending when `rx_half` rises. It clears only when `rx_half` is low or the receive FIFO is flushed. A status read does not clear it.
- R5: The character-timeout cause becomes pending on an `rx_char_tmo` pulse. It clears on `rx_pop` or on a status read. If a new pulse coincides with a clearing access, the cause stays pending.
- R6: The transmit-empty cause becomes pending when `tx_empty` rises. It clears on `tx_push`, on a status read, or on a transmit flush.
- R7: The transmit half-full cause becomes pending when `tx_half` falls, which means the FIFO has drained below half. It clears when `tx_half` rises again, on a status read, or on a transmit flush.
- R8: Writing timer control (offset 4) with bit0 = 1 loads the interval n from offset 3 and starts the timer. The timer cause becomes pending after n ticks of CLK_HZ/5000 cycles each, so `irq` in level style rises n*CLK_HZ/5000 + 1 cycles after the enabling write. The timer fires once. The cause stays pending through status reads and clears only on a timer-control write with bit0 = 0. A disable in the same cycle as a fire wins.
- R9: In level style, `irq` follows the OR of the enabled pending causes, one cycle after the causes change. In edge style, `irq` is high for exactly one cycle after each rising edge of that OR.
- R10: Writing offset 2 issues a one-cycle `rx_fifo_rst` pulse when data bit0 = 1 and a one-cycle `tx_fifo_rst` pulse when data bit1 = 1. The pulses appear in the cycle after the write. The write also clears the pending causes of the flushed side at once: receive half-full and character timeout for the receive side, transmit empty and transmit half-full for the transmit side.
- R11: `tx_xfer_en` is 0 in the cycle after `mcr_out1` is 1, and `rx_xfer_en` is 0 in the cycle after `mcr_out2` is 1. Each is 1 when its control input is 0.
- R12: Interrupt-enable bits are bit4 = timer, bit3 = character timeout, bit2 = transmit empty, bit1 = transmit half-full, bit0 = receive half-full. A pending cause whose enable is 0 never drives `irq`, but it stays latched and drives `irq` once enabled. Bits 7:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_rdata | output | 8 | Registered read data |
| rx_full | input | 1 | Receive FIFO full flag |
| rx_half | input | 1 | Receive FIFO at or above half |
| rx_empty | input | 1 | Receive FIFO empty flag |
| tx_full | input | 1 | Transmit FIFO full flag |
| tx_half | input | 1 | Transmit FIFO at or above half |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| rx_pop | input | 1 | Host read of a receive FIFO byte |
| tx_push | input | 1 | Host write of a transmit FIFO byte |
| rx_char_tmo | input | 1 | Character-timeout event pulse |
| mcr_out1 | input | 1 | UART modem-control output 1, blocks transmit transfer |
| mcr_out2 | input | 1 | UART modem-control output 2, blocks receive transfer |
| irq | output | 1 | Interrupt, level or edge style |
| rx_fifo_rst | output | 1 | Receive FIFO flush pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO flush pulse |
| rx_xfer_en | output | 1 | UART-to-receive-FIFO transfer allowed |
| tx_xfer_en | output | 1 | Transmit-FIFO-to-UART transfer allowed |
| flow_auto_en | output | 1 | Automatic RTS/CTS flow control enabled |
| fifo_en | output | 1 | External FIFO enabled |
| half_swap | output | 1 | Swap 8-byte halves of the 16-byte window |

## Verification
A pending bit that is stuck, set by the wrong edge, or cleared by the wrong access shows on `irq` in level style two clock edges after the stimulus. The first edge updates the pending bit and the second updates the registered line. For the timer and character-timeout causes, the same fault also shows in the status byte of the next read. A mis-ordered set/clear priority is visible only when the event and the clearing access fall in the same cycle, so those coincidences are driven on purpose. A timer that is off by one tick or one cycle moves the `irq` rise away from exactly n*CLK_HZ/5000 + 1 cycles after the arming write. A timer that re-fires without re-arming raises `irq` again within one interval after a disable.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam int AW = 3;
  localparam int DW = 8;

  localparam logic [AW-1:0] ADR_MODE = 3'd0;
  localparam logic [AW-1:0] ADR_IEN  = 3'd1;
  localparam logic [AW-1:0] ADR_STAT = 3'd2;
  localparam logic [AW-1:0] ADR_TINT = 3'd3;
  localparam logic [AW-1:0] ADR_TCTL = 3'd4;

  // cause index = interrupt-enable bit position
  localparam int NSRC    = 5;
  localparam int SRC_RXH = 0;
  localparam int SRC_TXH = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_CTO = 3;
  localparam int SRC_TMR = 4;

  // causes whose clear beats a simultaneous set
  localparam logic [NSRC-1:0] CLR_WINS = 5'b10000;

  localparam int TICKS_PER_SEC = 5000; // 0.2 ms step
endpackage

// File: rtl/sfx_regs.sv
module sfx_regs
  import sfx_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr,
  input  logic            rd,
  input  logic [DW-1:0]   status,
  output logic [DW-1:0]   rdata,
  output logic            lvl_mode,
  output logic            flow_en,
  output logic            ext_en,
  output logic            swap_en,
  output logic [NSRC-1:0] ien,
  output logic [TW-1:0]   interval,
  output logic            tmr_arm,
  output logic            tmr_stop,
  output logic            stat_rd,
  output logic            rx_flush,
  output logic            tx_flush,
  output logic            rx_rst_q,
  output logic            tx_rst_q
);
  logic tmr_on;
  logic [DW-1:0] rd_mux;

  assign stat_rd  = rd && (addr == ADR_STAT);
  assign rx_flush = wr && (addr == ADR_STAT) && wdata[0];
  assign tx_flush = wr && (addr == ADR_STAT) && wdata[1];
  assign tmr_arm  = wr && (addr == ADR_TCTL) && wdata[0];
  assign tmr_stop = wr && (addr == ADR_TCTL) && !wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_mode <= 1'b0;
      flow_en  <= 1'b0;
      ext_en   <= 1'b1;
      swap_en  <= 1'b0;
      ien      <= '0;
      interval <= '0;
      tmr_on   <= 1'b0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
    end else begin
      rx_rst_q <= rx_flush;
      tx_rst_q <= tx_flush;
      if (wr) begin
        case (addr)
          ADR_MODE: begin
            lvl_mode <= wdata[4];
            flow_en  <= wdata[3];
            ext_en   <= wdata[2];
            swap_en  <= wdata[0];
          end
          ADR_IEN:  ien      <= wdata[NSRC-1:0];
          ADR_TINT: interval <= wdata[TW-1:0];
          ADR_TCTL: tmr_on   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_MODE: rd_mux = {3'b000, lvl_mode, flow_en, ext_en, 1'b0, swap_en};
      ADR_IEN:  rd_mux = DW'(ien);
      ADR_STAT: rd_mux = status;
      ADR_TINT: rd_mux = DW'(interval);
      ADR_TCTL: rd_mux = DW'(tmr_on);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end
endmodule

// File: rtl/sfx_timer.sv
module sfx_timer #(
  parameter int TICK_DIV = 40000,
  parameter int TW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          stop,
  input  logic [TW-1:0] interval,
  output logic          fire
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] cnt_q;
  logic          run_q;
  logic          tick;

  assign tick = (pre_q == PRE_LAST);
  assign fire = run_q && tick && (cnt_q <= TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (arm) begin
      pre_q <= '0;
      cnt_q <= interval;
      run_q <= 1'b1;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick) cnt_q <= cnt_q - TW'(1);
      if (fire) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sfx_irq.sv
module sfx_irq
  import sfx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl_mode,
  input  logic [NSRC-1:0] ien,
  input  logic            rx_half,
  input  logic            tx_half,
  input  logic            tx_empty,
  input  logic            cto_evt,
  input  logic            rx_pop,
  input  logic            tx_push,
  input  logic            stat_rd,
  input  logic            rx_flush,
  input  logic            tx_flush,
  input  logic            tmr_fire,
  input  logic            tmr_stop,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  logic rxh_q, txh_q, txe_q, any_q;
  logic [NSRC-1:0] set_v, clr_v, nxt;
  logic any;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_RXH] = rx_half && !rxh_q;
    clr_v[SRC_RXH] = !rx_half || rx_flush;
    set_v[SRC_CTO] = cto_evt;
    clr_v[SRC_CTO] = rx_pop || stat_rd || rx_flush;
    set_v[SRC_TXE] = tx_empty && !txe_q;
    clr_v[SRC_TXE] = tx_push || stat_rd || tx_flush;
    set_v[SRC_TXH] = txh_q && !tx_half;
    clr_v[SRC_TXH] = (tx_half && !txh_q) || stat_rd || tx_flush;
    set_v[SRC_TMR] = tmr_fire;
    clr_v[SRC_TMR] = tmr_stop;
    for (int i = 0; i < NSRC; i++) begin
      if (CLR_WINS[i]) nxt[i] = clr_v[i] ? 1'b0 : (set_v[i] ? 1'b1 : pend[i]);
      else             nxt[i] = set_v[i] ? 1'b1 : (clr_v[i] ? 1'b0 : pend[i]);
    end
  end

  assign any = |(pend & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      rxh_q <= 1'b0;
      txh_q <= 1'b0;
      txe_q <= 1'b1;
      any_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      pend  <= nxt;
      rxh_q <= rx_half;
      txh_q <= tx_half;
      txe_q <= tx_empty;
      any_q <= any;
      irq   <= lvl_mode ? any : (any && !any_q);
    end
  end
endmodule

// File: rtl/sfx_irq_ctrl.sv
module sfx_irq_ctrl
  import sfx_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int TW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic [7:0]    reg_rdata,
  input  logic          rx_full,
  input  logic          rx_half,
  input  logic          rx_empty,
  input  logic          tx_full,
  input  logic          tx_half,
  input  logic          tx_empty,
  input  logic          rx_pop,
  input  logic          tx_push,
  input  logic          rx_char_tmo,
  input  logic          mcr_out1,
  input  logic          mcr_out2,
  output logic          irq,
  output logic          rx_fifo_rst,
  output logic          tx_fifo_rst,
  output logic          rx_xfer_en,
  output logic          tx_xfer_en,
  output logic          flow_auto_en,
  output logic          fifo_en,
  output logic          half_swap
);
  localparam int TICK_DIV = (CLK_HZ / TICKS_PER_SEC > 0) ? CLK_HZ / TICKS_PER_SEC : 1;

  logic            lvl_mode;
  logic [NSRC-1:0] ien;
  logic [NSRC-1:0] pend;
  logic [TW-1:0]   interval;
  logic            tmr_arm, tmr_stop, tmr_fire;
  logic            stat_rd, rx_flush, tx_flush;
  logic [DW-1:0]   status;

  assign status = {pend[SRC_TMR], pend[SRC_CTO], !rx_full, rx_half, rx_empty,
                   tx_full, tx_half, tx_empty};

  sfx_regs #(.TW(TW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rd(reg_rd), .status(status), .rdata(reg_rdata),
    .lvl_mode(lvl_mode), .flow_en(flow_auto_en), .ext_en(fifo_en),
    .swap_en(half_swap), .ien(ien), .interval(interval),
    .tmr_arm(tmr_arm), .tmr_stop(tmr_stop), .stat_rd(stat_rd),
    .rx_flush(rx_flush), .tx_flush(tx_flush),
    .rx_rst_q(rx_fifo_rst), .tx_rst_q(tx_fifo_rst)
  );

  sfx_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
    .clk(clk), .rst(rst), .arm(tmr_arm), .stop(tmr_stop),
    .interval(interval), .fire(tmr_fire)
  );

  sfx_irq u_irq (
    .clk(clk), .rst(rst), .lvl_mode(lvl_mode), .ien(ien),
    .rx_half(rx_half), .tx_half(tx_half), .tx_empty(tx_empty),
    .cto_evt(rx_char_tmo), .rx_pop(rx_pop), .tx_push(tx_push),
    .stat_rd(stat_rd), .rx_flush(rx_flush), .tx_flush(tx_flush),
    .tmr_fire(tmr_fire), .tmr_stop(tmr_stop), .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_xfer_en <= 1'b0;
      tx_xfer_en <= 1'b0;
    end else begin
      rx_xfer_en <= !mcr_out2;
      tx_xfer_en <= !mcr_out1;
    end
  end
endmodule

// File: rtl/sfx_irq_ctrl_chk.sv
module sfx_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] reg_addr,
  input logic       wd0,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       rdata_b1,
  input logic       rx_char_tmo,
  input logic       mcr_out1,
  input logic       mcr_out2,
  input logic       irq,
  input logic       rx_fifo_rst,
  input logic       tx_fifo_rst,
  input logic       rx_xfer_en,
  input logic       tx_xfer_en,
  input logic       lvl_mode,
  input logic [4:0] pend,
  input logic [4:0] ien
);
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd0) |=> !rdata_b1);

  p_stat_clears_cto_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd2 && !rx_char_tmo) |=> !pend[3]);

  p_tmr_stop_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd4 && !wd0) |=> !pend[4]);

  p_edge_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !lvl_mode && !(reg_wr && reg_addr == 3'd0)) |=> !irq);

  p_rx_flush_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd2) |=> (rx_fifo_rst == $past(wd0)));

  p_flush_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == 3'd2) |=> (!rx_fifo_rst && !tx_fifo_rst));

  p_tx_gate_r11: assert property (@(posedge clk) disable iff (rst)
    mcr_out1 |=> !tx_xfer_en);

  p_rx_gate_r11: assert property (@(posedge clk) disable iff (rst)
    mcr_out2 |=> !rx_xfer_en);

  p_masked_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    ((pend & ien) == 5'd0) |=> !irq);
endmodule

bind sfx_irq_ctrl sfx_irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .wd0(reg_wdata[0]),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .rdata_b1(reg_rdata[1]),
  .rx_char_tmo(rx_char_tmo), .mcr_out1(mcr_out1), .mcr_out2(mcr_out2),
  .irq(irq), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
  .rx_xfer_en(rx_xfer_en), .tx_xfer_en(tx_xfer_en),
  .lvl_mode(lvl_mode), .pend(pend), .ien(ien)
);

// File: tb/sfx_irq_ctrl_tb.sv
`timescale 1ns/1ps
module sfx_irq_ctrl_tb;
  localparam int CLK_HZ = 50_000;
  localparam int DIV    = CLK_HZ / 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic rx_full = 1'b0, rx_half = 1'b0, rx_empty = 1'b1;
  logic tx_full = 1'b0, tx_half = 1'b0, tx_empty = 1'b1;
  logic rx_pop = 1'b0, tx_push = 1'b0, rx_char_tmo = 1'b0;
  logic mcr_out1 = 1'b0, mcr_out2 = 1'b0;
  logic irq, rx_fifo_rst, tx_fifo_rst, rx_xfer_en, tx_xfer_en;
  logic flow_auto_en, fifo_en, half_swap;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sfx_irq_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .rx_full(rx_full), .rx_half(rx_half), .rx_empty(rx_empty),
    .tx_full(tx_full), .tx_half(tx_half), .tx_empty(tx_empty),
    .rx_pop(rx_pop), .tx_push(tx_push), .rx_char_tmo(rx_char_tmo),
    .mcr_out1(mcr_out1), .mcr_out2(mcr_out2), .irq(irq),
    .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
    .rx_xfer_en(rx_xfer_en), .tx_xfer_en(tx_xfer_en),
    .flow_auto_en(flow_auto_en), .fifo_en(fifo_en), .half_swap(half_swap)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    step(1);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic prep(input logic [7:0] mode, input logic [7:0] en);
    wr(3'd0, mode);
    wr(3'd1, en);
    wr(3'd2, 8'h03);
    step(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    rd(3'd0, d); chk("R1 mode default", d, 8'h04);
    rd(3'd1, d); chk("R1 enable default", d, 8'h00);
    rd(3'd3, d); chk("R1 interval default", d, 8'h00);
    rd(3'd4, d); chk("R1 timer control default", d, 8'h00);
    chk("R2 fifo_en default", {5'b0, flow_auto_en, fifo_en, half_swap}, 8'h02);
  endtask

  task automatic t_mode();
    logic [7:0] d;
    wr(3'd0, 8'hFF);
    rd(3'd0, d); chk("R2 reserved bit reads 0", d, 8'h1D);
    chk("R2 mode outputs", {5'b0, flow_auto_en, fifo_en, half_swap}, 8'h07);
    wr(3'd0, 8'h10);
    step(1);
    chk("R2 mode outputs cleared", {5'b0, flow_auto_en, fifo_en, half_swap}, 8'h00);
    wr(3'd1, 8'hFF);
    rd(3'd1, d); chk("R12 enable width", d, 8'h1F);
  endtask

  task automatic t_status();
    logic [7:0] d;
    prep(8'h14, 8'h00);
    rd(3'd2, d); chk("R3 idle status", d, 8'h29);
    rx_full = 1; rx_half = 1; rx_empty = 0; tx_full = 1; tx_half = 1; tx_empty = 0;
    step(1);
    rd(3'd2, d); chk("R3 busy status", d, 8'h16);
    rx_full = 0; rx_half = 0; rx_empty = 1; tx_full = 0; tx_half = 0; tx_empty = 1;
    step(2);
  endtask

  task automatic t_rx_half();
    logic [7:0] d;
    prep(8'h14, 8'h00);
    rx_half = 1; step(3);
    chk("R12 masked cause keeps irq low", {7'b0, irq}, 8'h00);
    wr(3'd1, 8'h01); step(1);
    chk("R12 latched cause drives irq once enabled", {7'b0, irq}, 8'h01);
    rd(3'd2, d); step(1);
    chk("R4 status read leaves rx half pending", {7'b0, irq}, 8'h01);
    rx_half = 0; step(2);
    chk("R4 clears below half", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_cto();
    logic [7:0] d;
    prep(8'h14, 8'h08);
    rx_char_tmo = 1; step(1); rx_char_tmo = 0; step(1);
    chk("R5 timeout raises irq", {7'b0, irq}, 8'h01);
    rx_pop = 1; step(1); rx_pop = 0; step(1);
    chk("R5 pop clears timeout", {7'b0, irq}, 8'h00);
    rx_char_tmo = 1; step(1); rx_char_tmo = 0; step(1);
    rd(3'd2, d);
    chk("R3 status shows timeout before clear", d & 8'hC0, 8'h40);
    step(1);
    chk("R5 status read clears timeout", {7'b0, irq}, 8'h00);
    reg_addr = 3'd2; reg_rd = 1; rx_char_tmo = 1;
    step(1);
    reg_rd = 0; rx_char_tmo = 0;
    step(1);
    chk("R5 new event beats clearing read", {7'b0, irq}, 8'h01);
    rx_pop = 1; step(1); rx_pop = 0; step(1);
  endtask

  task automatic t_tx_empty();
    logic [7:0] d;
    prep(8'h14, 8'h04);
    tx_empty = 0; step(1); tx_empty = 1; step(2);
    chk("R6 empty rise raises irq", {7'b0, irq}, 8'h01);
    tx_push = 1; step(1); tx_push = 0; step(1);
    chk("R6 push clears empty cause", {7'b0, irq}, 8'h00);
    tx_empty = 0; step(1); tx_empty = 1; step(2);
    rd(3'd2, d); step(1);
    chk("R6 status read clears empty cause", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_tx_half();
    logic [7:0] d;
    prep(8'h14, 8'h02);
    tx_half = 1; step(2);
    chk("R7 rise alone raises nothing", {7'b0, irq}, 8'h00);
    tx_half = 0; step(2);
    chk("R7 drain below half raises irq", {7'b0, irq}, 8'h01);
    tx_half = 1; step(2);
    chk("R7 refill to half clears", {7'b0, irq}, 8'h00);
    tx_half = 0; step(2);
    rd(3'd2, d); step(1);
    chk("R7 status read clears", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_flush();
    prep(8'h14, 8'h0F);
    rx_char_tmo = 1; step(1); rx_char_tmo = 0; step(1);
    wr(3'd2, 8'h01);
    chk("R10 rx flush pulse", {6'b0, tx_fifo_rst, rx_fifo_rst}, 8'h01);
    step(1);
    chk("R10 rx flush pulse ends", {6'b0, tx_fifo_rst, rx_fifo_rst}, 8'h00);
    chk("R10 rx flush clears timeout cause", {7'b0, irq}, 8'h00);
    tx_empty = 0; step(1); tx_empty = 1; step(2);
    wr(3'd2, 8'h02);
    chk("R10 tx flush pulse", {6'b0, tx_fifo_rst, rx_fifo_rst}, 8'h02);
    step(1);
    chk("R10 tx flush clears empty cause", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_edge();
    logic [7:0] d;
    prep(8'h04, 8'h08);
    rx_char_tmo = 1; step(1); rx_char_tmo = 0; step(1);
    chk("R9 edge pulse high", {7'b0, irq}, 8'h01);
    step(1);
    chk("R9 edge pulse one cycle", {7'b0, irq}, 8'h00);
    rd(3'd2, d);
    chk("R9 cause still pending in edge style", d & 8'h40, 8'h40);
  endtask

  task automatic timer_wait(input string req, input int exp);
    int k = 0;
    while (!irq && k < 200) begin step(1); k++; end
    chk(req, 8'(k), 8'(exp));
  endtask

  task automatic t_timer();
    logic [7:0] d;
    prep(8'h14, 8'h10);
    wr(3'd3, 8'd3);
    wr(3'd4, 8'h01);
    timer_wait("R8 timer latency", 3 * DIV + 1);
    step(50);
    rd(3'd2, d);
    chk("R8 timer pending after status read", d & 8'h80, 8'h80);
    step(1);
    chk("R8 timer holds irq", {7'b0, irq}, 8'h01);
    wr(3'd4, 8'h00); step(1);
    chk("R8 disable clears timer", {7'b0, irq}, 8'h00);
    step(60);
    chk("R8 no refire without rearm", {7'b0, irq}, 8'h00);
    wr(3'd4, 8'h01);
    timer_wait("R8 rearmed timer latency", 3 * DIV + 1);
    wr(3'd4, 8'h00); step(1);
  endtask

  task automatic t_gate();
    step(1);
    chk("R11 both transfers open", {6'b0, rx_xfer_en, tx_xfer_en}, 8'h03);
    mcr_out1 = 1; step(1);
    chk("R11 out1 blocks tx", {6'b0, rx_xfer_en, tx_xfer_en}, 8'h02);
    mcr_out1 = 0; mcr_out2 = 1; step(1);
    chk("R11 out2 blocks rx", {6'b0, rx_xfer_en, tx_xfer_en}, 8'h01);
    mcr_out2 = 0; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(2);
    t_reset();
    t_mode();
    t_status();
    t_rx_half();
    t_cto();
    t_tx_empty();
    t_tx_half();
    t_flush();
    t_edge();
    t_timer();
    t_gate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule